// File: doc/BRIEF.md
# Strip Bit-Matrix Transpose Streamer

This block turns a horizontal strip of eight frame-buffer rows, stored one bit per pixel with the leftmost pixel in the most significant bit, into a stream of bytes in which each byte carries eight vertically adjacent pixels of one column. It is used to feed a display memory whose native scan order is rotated by 90 degrees against the frame buffer: software (or a sequencer) starts one strip per eight rows, aiming the display's column address at the strip index and its row address at zero, and forwards the bytes this block produces.

For each group of eight output bytes the block reads one byte from each of the eight rows, at the strip base plus the row number times the row stride plus the current column byte index, and then transposes the 8x8 bit matrix on the fly. In forward mode the column byte index starts at zero and rises by one per group. In reversed mode it starts at the last byte of the row and falls; the bits of each fetched byte are consumed from the least significant end, and when the visible height is not a whole number of bytes, every fetched byte is first realigned by a sub-byte shift that pulls the missing high bits from the byte at the next lower address. Emission stops as soon as the requested pixel count has been sent, even inside a group.

The controller is a four-state machine: IDLE (waiting for start), FETCH (one memory read issued per cycle), DRAIN (the last read returns), EMIT (bytes offered on the valid/ready output). Transitions: IDLE to FETCH on start with a non-zero pixel count; FETCH to DRAIN after the last read of the group; DRAIN to EMIT always; EMIT to FETCH after the eighth accepted byte of a group when pixels remain; EMIT to IDLE when the last requested byte is accepted.

Top module: `tps_strip_transpose`

## Requirements
- R1: After reset, out_valid, busy and mem_rd_en are all 0.
- R2: Each group reads row j (j = 0..7, in that order) at base + j*stride + col, with a read latency of one cycle; in reversed mode with a non-zero offset and col > 0, eight more reads fetch base + j*stride + col - 1, so a group costs 8 or 16 reads.
- R3: In forward mode col starts at 0 and rises by one per group; output byte i of a group (i = 0..7) has bit 7-j equal to bit 7-i of row j's fetched byte, so row 0 lands in the output MSB.
- R4: In reversed mode col starts at stride-1 and falls by one per group; output byte i has bit 7-j equal to bit i of row j's (realigned) byte.
- R5: In reversed mode with offset k = align_off (1..7), each row byte is realigned to ((cur >> k) | (prev << (8-k))) truncated to 8 bits, where prev is the byte at the next lower address of the same row.
- R6: When col = 0, prev is taken as 0 and no read is issued below base_addr.
- R7: Exactly pix_count bytes are emitted, even if that ends a group early; busy then returns to 0. A start with pix_count = 0 is ignored.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged.
- R9: A start pulse while busy is 1 is ignored; the running strip continues with its latched parameters.
- R10: In forward mode align_off has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a strip with the parameters below (sampled in IDLE only) |
| rev_mode | input | 1 | 1: reversed column walk with realignment, 0: forward |
| base_addr | input | AW | Byte address of row 0, column byte 0 of the strip |
| stride | input | SW | Bytes per frame-buffer row |
| pix_count | input | CW | Number of output bytes to emit |
| align_off | input | 3 | Sub-byte realignment shift for reversed mode |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Column byte, topmost row in bit 7 |
| out_ready | input | 1 | Consumer accepts out_data |
| busy | output | 1 | A strip is in progress |

## Verification
The hardest situation to reach is a reversed strip with a non-zero offset that walks all the way down to column 0, because only then does the prev-is-zero rule apply and a wrong address would fall below the strip base. The bench starts reversed strips whose pixel count equals stride times eight, so the final group sits at column 0, and a read monitor flags any address under the base while the expected bytes are computed with prev forced to zero there. Back-pressure with an irregular ready pattern and a stray start pulse during a strip are layered onto those runs.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EMIT  = 2'd3
    } tps_state_e;

    localparam int unsigned LANES = 8;
endpackage

// File: rtl/tps_realign.sv
`timescale 1ns/1ps
module tps_realign (
    input  logic [7:0] cur,
    input  logic [7:0] prev,
    input  logic [2:0] shift,
    output logic [7:0] aligned
);
    logic [15:0] pair;
    always_comb begin
        pair    = {prev, cur} >> shift;
        aligned = pair[7:0];
    end
endmodule

// File: rtl/tps_bit_transpose.sv
`timescale 1ns/1ps
module tps_bit_transpose (
    input  logic [7:0][7:0] rows,
    input  logic            rev,
    output logic [7:0][7:0] cols
);
    for (genvar gi = 0; gi < 8; gi++) begin : g_col
        for (genvar gj = 0; gj < 8; gj++) begin : g_row
            assign cols[gi][7-gj] = rev ? rows[gj][gi] : rows[gj][7-gi];
        end
    end
endmodule

// File: rtl/tps_strip_transpose.sv
`timescale 1ns/1ps
module tps_strip_transpose
    import tps_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rev_mode,
    input  logic [AW-1:0] base_addr,
    input  logic [SW-1:0] stride,
    input  logic [CW-1:0] pix_count,
    input  logic [2:0]    align_off,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    output logic          busy
);
    localparam int IW = $clog2(LANES) + 1;

    tps_state_e state_q, state_d;

    logic          rev_q;
    logic [AW-1:0] base_q;
    logic [SW-1:0] stride_q;
    logic [2:0]    off_q;
    logic [CW-1:0] left_q;
    logic [SW-1:0] col_q;
    logic [IW-1:0] rd_idx_q;
    logic          rd_pend_q;
    logic [IW-1:0] rd_slot_q;
    logic [2:0]    emit_idx_q;
    logic [7:0][7:0] cur_q;
    logic [7:0][7:0] prev_q;
    logic [7:0][7:0] aligned;
    logic [7:0][7:0] cols;

    logic          need_prev;
    logic [IW-1:0] last_idx;
    logic          fire;
    logic          launch;
    logic          group_end;
    logic          strip_end;

    assign need_prev = rev_q && (off_q != 3'd0) && (col_q != '0);
    assign last_idx  = need_prev ? IW'(2*LANES-1) : IW'(LANES-1);
    assign fire      = (state_q == ST_EMIT) && out_ready;
    assign launch    = (state_q == ST_IDLE) && start && (pix_count != '0);
    assign strip_end = fire && (left_q == CW'(1));
    assign group_end = fire && (emit_idx_q == 3'd7) && !strip_end;

    for (genvar gr = 0; gr < LANES; gr++) begin : g_align
        tps_realign u_align (
            .cur     (cur_q[gr]),
            .prev    (prev_q[gr]),
            .shift   (off_q),
            .aligned (aligned[gr])
        );
    end

    tps_bit_transpose u_xpose (
        .rows (aligned),
        .rev  (rev_q),
        .cols (cols)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_FETCH;
            ST_FETCH: if (rd_idx_q == last_idx) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_EMIT;
            ST_EMIT: begin
                if (strip_end)      state_d = ST_IDLE;
                else if (group_end) state_d = ST_FETCH;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q      <= 1'b0;
            base_q     <= '0;
            stride_q   <= '0;
            off_q      <= '0;
            left_q     <= '0;
            col_q      <= '0;
            rd_idx_q   <= '0;
            rd_pend_q  <= 1'b0;
            rd_slot_q  <= '0;
            emit_idx_q <= '0;
            cur_q      <= '0;
            prev_q     <= '0;
        end else begin
            rd_pend_q <= (state_q == ST_FETCH);
            if (launch) begin
                rev_q      <= rev_mode;
                base_q     <= base_addr;
                stride_q   <= stride;
                off_q      <= rev_mode ? align_off : 3'd0;
                left_q     <= pix_count;
                col_q      <= rev_mode ? stride - SW'(1) : '0;
                rd_idx_q   <= '0;
                emit_idx_q <= '0;
            end
            if (state_q == ST_FETCH) begin
                rd_idx_q  <= rd_idx_q + IW'(1);
                rd_slot_q <= rd_idx_q;
                if (rd_idx_q == '0) prev_q <= '0;
            end
            if (rd_pend_q) begin
                if (rd_slot_q[IW-1]) prev_q[rd_slot_q[2:0]] <= mem_rd_data;
                else                 cur_q[rd_slot_q[2:0]]  <= mem_rd_data;
            end
            if (fire) begin
                left_q     <= left_q - CW'(1);
                emit_idx_q <= emit_idx_q + 3'd1;
            end
            if (group_end) begin
                col_q      <= rev_q ? col_q - SW'(1) : col_q + SW'(1);
                rd_idx_q   <= '0;
                emit_idx_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_data  = cols[emit_idx_q];
        mem_rd_en = (state_q == ST_FETCH);
        mem_addr  = base_q
                  + AW'(rd_idx_q[2:0]) * AW'(stride_q)
                  + AW'(col_q)
                  - AW'(rd_idx_q[IW-1]);
    end

    // Assertions
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !mem_rd_en));

    p_no_read_below_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= base_q));

    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_end_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid && out_ready));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(base_q) && $stable(stride_q) && $stable(rev_q)));

    p_no_fetch_during_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_rd_en);
endmodule

// File: tb/tb_tps_strip_transpose.sv
`timescale 1ns/1ps
module tb_tps_strip_transpose;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          rev_mode;
    logic [AW-1:0] base_addr;
    logic [SW-1:0] stride;
    logic [CW-1:0] pix_count;
    logic [2:0]    align_off;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rd_data;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_ready;
    logic          busy;

    logic [7:0] mem [256];
    int rd_cnt = 0;
    int low_viol = 0;
    int floor_addr = 0;
    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tps_strip_transpose #(.AW(AW), .SW(SW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rev_mode(rev_mode),
        .base_addr(base_addr), .stride(stride), .pix_count(pix_count),
        .align_off(align_off), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_addr[7:0]];
            rd_cnt <= rd_cnt + 1;
            if (int'(mem_addr) < floor_addr) low_viol <= low_viol + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int base, input int strd, input bit rev,
                                            input int off, input int idx);
        int g, i, col;
        logic [7:0] cur, prv, a, r;
        g = idx / 8;
        i = idx % 8;
        col = rev ? (strd - 1 - g) : g;
        r = 8'h00;
        for (int j = 0; j < 8; j++) begin
            cur = mem[(base + j*strd + col) & 255];
            prv = (rev && off != 0 && col != 0) ? mem[(base + j*strd + col - 1) & 255] : 8'h00;
            if (rev && off != 0) a = 8'((cur >> off) | (prv << (8 - off)));
            else                 a = cur;
            r[7-j] = rev ? a[i] : a[7-i];
        end
        return r;
    endfunction

    function automatic int exp_reads(input int strd, input bit rev, input int off, input int npix);
        int n, col;
        n = 0;
        for (int g = 0; g < (npix + 7) / 8; g++) begin
            col = rev ? (strd - 1 - g) : g;
            n += 8;
            if (rev && off != 0 && col != 0) n += 8;
        end
        return n;
    endfunction

    // One strip: rdy_mode 0 = always ready, 1 = irregular stalls; poke = stray start while busy
    task automatic run_strip(input string tag, input int base, input int strd, input bit rev,
                             input int off, input int npix, input int rdy_mode, input bit poke);
        int got, rd0, viol0, cyc;
        bit stall;
        logic [7:0] held, e;
        got = 0; cyc = 0; stall = 1'b0; held = 8'h00;
        @(negedge clk);
        rd0 = rd_cnt; viol0 = low_viol; floor_addr = base;
        rev_mode = rev; base_addr = AW'(base); stride = SW'(strd);
        pix_count = CW'(npix); align_off = 3'(off); start = 1'b1;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            base_addr = AW'(8'hC0);
            rev_mode = ~rev;
            align_off = 3'(off + 1);
            if (poke && cyc == 4) begin
                start = 1'b1;
                check(busy == 1'b1, "R9 busy at stray start", int'(busy), 1);
            end
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (out_valid) begin
                if (stall)
                    check(out_data == held, {tag, " R8 hold"}, out_data, held);
                if (out_ready) begin
                    e = exp_byte(base, strd, rev, off, got);
                    check(out_data == e, tag, out_data, e);
                    got++;
                end
            end
            stall = out_valid && !out_ready;
            held = out_data;
            if (!busy && cyc > 1) break;
            if (cyc > 3000) break;
        end
        start = 1'b0;
        out_ready = 1'b0;
        check(got == npix, {tag, " R7 byte count"}, got, npix);
        check(rd_cnt - rd0 == exp_reads(strd, rev, off, npix), {tag, " R2 read count"},
              rd_cnt - rd0, exp_reads(strd, rev, off, npix));
        check(low_viol == viol0, {tag, " R6 read below base"}, low_viol - viol0, 0);
        @(negedge clk);
        check(!out_valid && !busy, {tag, " R7 idle after strip"}, int'({out_valid, busy}), 0);
    endtask

    task automatic test_reset();
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(!busy, "R1 busy", busy, 0);
        check(!mem_rd_en, "R1 mem_rd_en", mem_rd_en, 0);
    endtask

    task automatic test_zero_count();
        @(negedge clk);
        pix_count = '0; start = 1'b1; base_addr = '0; stride = SW'(4);
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R7 zero count ignored", busy, 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'((k * 73 + 29) ^ (k >> 3));
        rst_n = 1'b0; start = 1'b0; rev_mode = 1'b0; base_addr = '0; stride = '0;
        pix_count = '0; align_off = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_strip("R3 forward full",           16'h10, 4, 1'b0, 0, 32, 0, 1'b0);
        run_strip("R10 forward offset ignored", 16'h10, 4, 1'b0, 3, 32, 1, 1'b0);
        run_strip("R4 reversed no offset",     16'h40, 3, 1'b1, 0, 24, 0, 1'b0);
        run_strip("R5 reversed offset 5",      16'h60, 4, 1'b1, 5, 32, 0, 1'b0);
        run_strip("R7 reversed partial",       16'h60, 4, 1'b1, 2, 13, 0, 1'b0);
        run_strip("R9 stray start",            16'h20, 5, 1'b0, 0, 5,  1, 1'b1);
        run_strip("R6 reversed offset 7",      16'h90, 2, 1'b1, 7, 16, 1, 1'b0);
        test_zero_count();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule